// File: doc/BRIEF.md
# Port Pin Direction Priority Controller

This block holds the direction setting for an 8-bit general purpose port and works out, pin by pin, the direction and drive mode that reach the pad. A small register bus writes and reads an 8-bit direction register. A 1 in that register makes a pin an output and a 0 makes it an input. All eight bits clear on reset.

The upper four pins (4 to 7) can be taken over by on-chip peripherals. A routing select and an enable say whether each function owns a pin. A serial peripheral interface function has top priority and drives the pin direction from its own per-pin request. Next comes a two-wire bus function, available on pins 4 and 7 only, which forces an open-drain output. After that comes a PWM channel (channel k on pin 4+k), which forces a push-pull output. The register bit applies only when none of these is in control.

The results leave the block combinationally as per-pin output-enable and open-drain flags. A register read always returns the stored bits, never the overridden result.

Top module: `pin_dir_arbiter`

## Requirements
- R1: After reset the stored direction bits are all 0, so `oe_o` and `od_o` are 8'h00 and a read at the register address returns 8'h00.
- R2: A rising clock edge with `bus_we` high and `bus_addr` equal to `REG_ADDR` (default 16'h024A) stores `bus_wdata`. A read at `REG_ADDR` returns the stored bits combinationally, whatever overrides are active.
- R3: A write to any other address leaves the stored bits unchanged.
- R4: A read at any other address returns 8'h00.
- R5: Pins 0 to 3 take `oe_o[i]` from stored bit i, and their `od_o[i]` is 0.
- R6: On pin 4+k (k = 0..3), when `spi_en` and `spi_route[k]` are both 1, `oe_o[4+k]` equals `spi_dir_req[k]` and `od_o[4+k]` is 0, whatever the other functions are doing.
- R7: On pin 4 (`iic_route[0]`) and pin 7 (`iic_route[1]`), when the serial peripheral function is not in control and `iic_en` and the matching route bit are 1, both `oe_o` and `od_o` of that pin are 1.
- R8: On pin 4+k, when neither higher function is in control and `pwm_en[k]` and `pwm_route[k]` are both 1, `oe_o[4+k]` is 1 and `od_o[4+k]` is 0.
- R9: On pin 4+k, when no function is in control, `oe_o[4+k]` equals stored bit 4+k and `od_o[4+k]` is 0.
- R10: `oe_o` and `od_o` follow changes of the override inputs within the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register bus address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data |
| spi_en | input | 1 | Serial peripheral function enable |
| spi_route | input | 4 | Serial peripheral routed to pin 4+k |
| spi_dir_req | input | 4 | Direction request from the serial peripheral for pin 4+k |
| iic_en | input | 1 | Two-wire bus function enable |
| iic_route | input | 2 | Two-wire bus routed to pin 4 (bit 0) or pin 7 (bit 1) |
| pwm_en | input | 4 | PWM channel k enable |
| pwm_route | input | 4 | PWM channel k routed to pin 4+k |
| oe_o | output | 8 | Effective output enable per pin |
| od_o | output | 8 | Open-drain flag per pin |

## Verification
The hardest case to reach from the ports is a combination in which several functions claim the same pin at once while the stored bit disagrees with all of them. An example is a routed PWM channel and a stored 0 on a pin where the two-wire bus is routed but its shared enable is low. A flat sweep of the 20 override input bits with a fixed prime stride reaches these cases. The sweep runs under four stored-bit patterns, including alternating ones that put each pin's stored bit against the forced value. Expected values for every pin come from a priority model in the bench.

// File: rtl/pin_dir_arbiter.sv
module pin_dir_arbiter #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] REG_ADDR = 16'h024A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              spi_en,
  input  logic [3:0]        spi_route,
  input  logic [3:0]        spi_dir_req,
  input  logic              iic_en,
  input  logic [1:0]        iic_route,
  input  logic [3:0]        pwm_en,
  input  logic [3:0]        pwm_route,
  output logic [7:0]        oe_o,
  output logic [7:0]        od_o
);
  logic [7:0] ddr_q;
  logic       hit;

  assign hit = (bus_addr == REG_ADDR);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)             ddr_q <= 8'h00;
    else if (bus_we && hit) ddr_q <= bus_wdata;

  assign bus_rdata = hit ? ddr_q : 8'h00;

  assign oe_o[3:0] = ddr_q[3:0];
  assign od_o[3:0] = 4'h0;

  for (genvar k = 0; k < 4; k++) begin : g_hi
    localparam bit HAS_IIC = (k == 0) || (k == 3);
    localparam int IIC_IDX = (k == 3) ? 1 : 0;
    logic spi_act, iic_act, pwm_act;
    assign spi_act = spi_en & spi_route[k];
    assign iic_act = HAS_IIC ? (iic_en & iic_route[IIC_IDX]) : 1'b0;
    assign pwm_act = pwm_en[k] & pwm_route[k];
    assign oe_o[4+k] = spi_act ? spi_dir_req[k] :
                       (iic_act | pwm_act) ? 1'b1 : ddr_q[4+k];
    assign od_o[4+k] = ~spi_act & iic_act;
  end
endmodule

module pin_dir_arbiter_chk #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] REG_ADDR = 16'h024A
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic [7:0]        bus_wdata,
  input logic [7:0]        bus_rdata,
  input logic              spi_en,
  input logic [3:0]        spi_route,
  input logic [3:0]        spi_dir_req,
  input logic [3:0]        pwm_en,
  input logic [3:0]        pwm_route,
  input logic [7:0]        oe_o,
  input logic [7:0]        od_o,
  input logic [7:0]        ddr_q
);
  assert_write_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == REG_ADDR) |=> ddr_q == $past(bus_wdata));

  assert_foreign_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && bus_addr == REG_ADDR) |=> $stable(ddr_q));

  assert_foreign_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr != REG_ADDR) |-> bus_rdata == 8'h00);

  assert_spi_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_en && spi_route[0]) |-> (oe_o[4] == spi_dir_req[0] && !od_o[4]));

  assert_od_is_output_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (|od_o) |-> ((od_o & ~oe_o) == 8'h00));

  assert_pwm_forces_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_en[1] && pwm_route[1] && !(spi_en && spi_route[1])) |-> (oe_o[5] && !od_o[5]));
endmodule

bind pin_dir_arbiter pin_dir_arbiter_chk #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .spi_en(spi_en),
  .spi_route(spi_route), .spi_dir_req(spi_dir_req), .pwm_en(pwm_en),
  .pwm_route(pwm_route), .oe_o(oe_o), .od_o(od_o), .ddr_q(ddr_q)
);

// File: tb/pin_dir_arbiter_bench.sv
`timescale 1ns/1ps
module pin_dir_arbiter_bench;
  localparam logic [15:0] RA = 16'h024A;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] bus_addr = RA;
  logic bus_we = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic spi_en = 1'b0, iic_en = 1'b0;
  logic [3:0] spi_route = '0, spi_dir_req = '0, pwm_en = '0, pwm_route = '0;
  logic [1:0] iic_route = '0;
  logic [7:0] oe_o, od_o;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pin_dir_arbiter u_pin_dir_arbiter (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .spi_en(spi_en),
    .spi_route(spi_route), .spi_dir_req(spi_dir_req), .iic_en(iic_en),
    .iic_route(iic_route), .pwm_en(pwm_en), .pwm_route(pwm_route),
    .oe_o(oe_o), .od_o(od_o)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic write_reg(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; bus_addr = RA;
    #1;
  endtask

  // Priority model: pin 4+k, returns {od, oe} and the governing rule
  task automatic model(input int k, input logic [7:0] ddr, output logic oe, output logic od,
                       output string rule);
    bit has_iic = (k == 0) || (k == 3);
    bit iic_sel = (k == 0) ? iic_route[0] : (k == 3) ? iic_route[1] : 1'b0;
    if (spi_en && spi_route[k]) begin
      oe = spi_dir_req[k]; od = 1'b0; rule = "R6";
    end else if (has_iic && iic_en && iic_sel) begin
      oe = 1'b1; od = 1'b1; rule = "R7";
    end else if (pwm_en[k] && pwm_route[k]) begin
      oe = 1'b1; od = 1'b0; rule = "R8";
    end else begin
      oe = ddr[4+k]; od = 1'b0; rule = "R9";
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] pats [4];
    pats[0] = 8'h00; pats[1] = 8'hFF; pats[2] = 8'hA5; pats[3] = 8'h5A;
    #12;
    // R1: reset state
    check("R1 oe after reset", oe_o, 8'h00);
    check("R1 od after reset", od_o, 8'h00);
    check("R1 read after reset", bus_rdata, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 read after release", bus_rdata, 8'h00);

    // R2: write then read
    write_reg(RA, 8'h3C);
    check("R2 read back", bus_rdata, 8'h3C);
    check("R5 low pins follow register", {4'h0, oe_o[3:0]}, 8'h0C);

    // R3: foreign writes ignored
    write_reg(RA + 16'd1, 8'hFF);
    write_reg(16'h0000, 8'h81);
    write_reg(RA ^ 16'h8000, 8'h77);
    check("R3 foreign write ignored", bus_rdata, 8'h3C);
    check("R3 oe unchanged", oe_o, 8'h3C);

    // R4: foreign read returns zero
    bus_addr = RA - 16'd1; #1;
    check("R4 foreign read", bus_rdata, 8'h00);
    bus_addr = 16'hFFFF; #1;
    check("R4 foreign read all-ones addr", bus_rdata, 8'h00);
    bus_addr = RA; #1;

    // R2: read returns stored bits even under overrides
    spi_en = 1'b1; spi_route = 4'hF; spi_dir_req = 4'h0; #1;
    check("R2 read ignores overrides", bus_rdata, 8'h3C);
    check("R6 spi drives all high pins", oe_o, 8'h0C);
    spi_en = 1'b0; spi_route = 4'h0; #1;

    // R6..R10: swept override space, no clock between vectors (R10)
    foreach (pats[p]) begin
      write_reg(RA, pats[p]);
      for (int n = 0; n < (1 << 20); n += 97) begin
        logic [19:0] v = n[19:0];
        {spi_en, spi_route, spi_dir_req, iic_en, iic_route, pwm_en, pwm_route} = v;
        #1;
        check("R5 low pins oe", {4'h0, oe_o[3:0]}, {4'h0, pats[p][3:0]});
        check("R5 low pins od", {4'h0, od_o[3:0]}, 8'h00);
        for (int k = 0; k < 4; k++) begin
          logic eo, ed;
          string rule;
          model(k, pats[p], eo, ed, rule);
          check($sformatf("%s R10 pin %0d {od,oe}", rule, 4 + k),
                {6'h0, od_o[4+k], oe_o[4+k]}, {6'h0, ed, eo});
        end
      end
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule